// File: doc/BRIEF.md
# ADC Conversion Channel Sequencer

This block sequences a 10-bit successive-approximation conversion from a register-style control interface. Software raises a start strobe, picks single or free-running operation, and gives an input channel and a reference source. The block captures those selections at fixed points in the conversion, drives the analog multiplexer and the reference switch, and runs the bit-by-bit approximation against a comparator stub. It then presents the result together with a completion flag and a flag that marks a result taken just after a reference switch.

All conversion timing advances only on cycles where the ADC clock enable is high. The selections are held in shadow registers, so software may rewrite them while a conversion runs. In free-running mode the next conversion's selections are captured on the same tick that finishes the current one. A channel change made after a completion therefore shows up two results later, not in the next result.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, busy, done, suspect, result, mux_sel and ref_act are all zero.
- R2: A start strobe is accepted only while enabled and not busy, and busy reads one from the next clock. In single mode busy drops on the completion tick. A strobe while disabled or busy has no effect.
- R3: Channel and reference are captured on the first ADC tick after a start is accepted. Writes to chan_sel or ref_sel after that tick do not change the conversion in progress.
- R4: A conversion lasts 13 ADC ticks, the capture tick included. Result and done update on the 13th tick and at no other time. With the tick enable held high, done is first seen 14 clocks after the start is accepted.
- R5: The result equals the held input level, saturated to 0x3FF when the level is at or above the reference (level code 1024 or more).
- R6: done is cleared by a one on clr_done. When a completion and a clear fall in the same clock, done stays set.
- R7: suspect is updated with each result. It is one exactly when the reference captured for that conversion differs from the reference of the previous capture. The value before the first capture is code 0.
- R8: In free-running mode a new conversion starts right after each completion. Its channel and reference are captured on the completion tick itself, so a change made after a completion first appears in the result after the next one.
- R9: Clearing en aborts any conversion. busy is zero on the next clock, and result and done are left unchanged.
- R10: ref_sel code 0 selects the analog supply, 1 the internal 1.1 V source, and 2 or 3 the external reference pin. ref_act shows the captured source as 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable; low aborts |
| start_wr | input | 1 | Start strobe (write of one to the start bit) |
| free_run | input | 1 | 1 = free-running, 0 = single conversion |
| clr_done | input | 1 | Write of one to the completion flag |
| chan_sel | input | CH_W | Requested input channel |
| ref_sel | input | 2 | Requested reference source code |
| adc_ce | input | 1 | ADC clock tick enable |
| ain_level | input | RES_W+1 | Stand-in analog level of the selected channel, in LSBs of the active reference |
| busy | output | 1 | Start bit readback: conversion in progress |
| mux_sel | output | CH_W | Captured channel driving the analog multiplexer |
| ref_act | output | 2 | Captured reference source driving the reference switch |
| result | output | RES_W | Last conversion result |
| done | output | 1 | Completion flag |
| suspect | output | 1 | Last result follows a reference switch |

## Verification
The bench builds the block with its defaults, a 10-bit result and eight channels. The stand-in level rises by channel, so channel 7 on the external reference exceeds full scale and brings the saturation code within reach. The tick enable is run both at every clock and at every third clock. This exposes the difference between counting clocks and counting ADC ticks, and it leaves room to rewrite the selections between ticks. The free-running run places a channel change right after a completion, where the two-results-later rule applies.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and helpers for the conversion sequencer.
// Assumes a two-bit reference code from the control interface.
package adc_seq_pkg;

    // Captured reference source driving the reference switch
    typedef enum logic [1:0] {
        REF_SUPPLY  = 2'd0,
        REF_BANDGAP = 2'd1,
        REF_PIN     = 2'd2
    } ref_src_e;

    // Per-tick events decoded from the conversion counter
    typedef struct packed {
        logic capture;
        logic sample;
        logic decide;
        logic finish;
    } tick_ev_t;

    // Map the raw reference code onto a source; code 3 also selects the pin
    function automatic ref_src_e norm_ref(input logic [1:0] code);
        ref_src_e r;
        case (code)
            2'd0:    r = REF_SUPPLY;
            2'd1:    r = REF_BANDGAP;
            default: r = REF_PIN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: conversion timing controller.
// Tracks the busy state and a tick counter across RES_W+3 ADC ticks and
// decodes capture, sample, bit-decision and finish events.
// Assumes adc_ce marks ADC clock ticks and en low means abort.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         start_wr,
    input  logic                         free_run,
    input  logic                         adc_ce,
    output logic                         busy,
    output tick_ev_t                     ev,
    output logic [$clog2(RES_W)-1:0]     bit_idx
);
    localparam int CONV_TICKS = RES_W + 3;
    localparam int LAST       = CONV_TICKS - 1;
    localparam int CNT_W      = $clog2(CONV_TICKS);
    localparam int IDX_W      = $clog2(RES_W);

    logic [CNT_W-1:0] cnt_q;
    logic             first_q;
    logic             tick;
    logic             at_last;
    logic [CNT_W-1:0] idx_full;

    // Tick qualification and counter decode
    always_comb begin
        tick       = busy && adc_ce && en;
        at_last    = (cnt_q == CNT_W'(LAST));
        ev.capture = tick && ((cnt_q == '0 && first_q) || (at_last && free_run));
        ev.sample  = tick && (cnt_q == CNT_W'(1));
        ev.decide  = tick && (cnt_q >= CNT_W'(2)) && (cnt_q < CNT_W'(LAST));
        ev.finish  = tick && at_last;
        idx_full   = CNT_W'(RES_W + 1) - cnt_q;
        bit_idx    = idx_full[IDX_W-1:0];
    end

    // Busy, first-conversion flag and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (!en) begin
            busy    <= 1'b0;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (start_wr && !busy) begin
            busy    <= 1'b1;
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (tick) begin
            if (at_last) begin
                cnt_q   <= '0;
                first_q <= 1'b0;
                busy    <= free_run;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == '0) first_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_seq_selhold.sv
// Module: shadow capture of channel and reference selections.
// Captures both on a capture event. Remembers whether the reference
// changed against the previous capture and publishes that with the result.
// Assumes capture and finish may coincide (free-running restart).
module adc_seq_selhold
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            finish,
    input  logic [CH_W-1:0] chan_sel,
    input  logic [1:0]      ref_sel,
    output logic [CH_W-1:0] mux_sel,
    output logic [1:0]      ref_act,
    output logic            suspect
);
    ref_src_e ref_q;
    ref_src_e ref_new;
    logic     pend_q;

    // Normalised reference request
    always_comb ref_new = norm_ref(ref_sel);

    // Shadow capture of the selections and the pending suspect mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_sel <= '0;
            ref_q   <= REF_SUPPLY;
            pend_q  <= 1'b0;
        end else if (capture) begin
            mux_sel <= chan_sel;
            ref_q   <= ref_new;
            pend_q  <= (ref_new != ref_q);
        end
    end

    // Suspect flag follows the conversion that just finished
    always_ff @(posedge clk) begin
        if (!rst_n)      suspect <= 1'b0;
        else if (finish) suspect <= pend_q;
    end

    assign ref_act = ref_q;

endmodule

// File: rtl/adc_cmp_stub.sv
// Module: synthesizable stand-in for the analog comparator.
// Reports whether the held level reaches the trial DAC code.
// Assumes the level is expressed in LSBs of the active reference.
module adc_cmp_stub #(
    parameter int RES_W = 10
) (
    input  logic [RES_W:0]   held,
    input  logic [RES_W-1:0] trial,
    output logic             ge
);
    // Magnitude compare of held level against the trial code
    always_comb ge = (held >= {1'b0, trial});
endmodule

// File: rtl/adc_sar_core.sv
// Module: sample hold and successive-approximation register.
// Holds the level on the sample event, resolves one bit per decide event
// from MSB down, and loads the result register on the finish event.
// Assumes bit_idx counts down from RES_W-1 to 0 over the decide events.
module adc_sar_core #(
    parameter int RES_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_en,
    input  logic                     decide_en,
    input  logic                     finish_en,
    input  logic [$clog2(RES_W)-1:0] bit_idx,
    input  logic [RES_W:0]           level,
    output logic [RES_W-1:0]         result
);
    logic [RES_W:0]   held_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] trial;
    logic             ge;

    // Trial code: accumulated bits plus the bit under test
    always_comb trial = acc_q | (RES_W'(1) << bit_idx);

    adc_cmp_stub #(.RES_W(RES_W)) u_cmp (
        .held  (held_q),
        .trial (trial),
        .ge    (ge)
    );

    // Sample hold and approximation register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            acc_q  <= '0;
        end else if (sample_en) begin
            held_q <= level;
            acc_q  <= '0;
        end else if (decide_en && ge) begin
            acc_q <= trial;
        end
    end

    // Result register, written only at completion
    always_ff @(posedge clk) begin
        if (!rst_n)         result <= '0;
        else if (finish_en) result <= acc_q;
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
// Module: top of the conversion channel sequencer.
// Ties the timing controller, selection shadow and SAR core together and
// owns the completion flag. Assumes one clock domain; adc_ce paces ticks.
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_wr,
    input  logic             free_run,
    input  logic             clr_done,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [1:0]       ref_sel,
    input  logic             adc_ce,
    input  logic [RES_W:0]   ain_level,
    output logic             busy,
    output logic [CH_W-1:0]  mux_sel,
    output logic [1:0]       ref_act,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             suspect
);
    tick_ev_t                 ev;
    logic [$clog2(RES_W)-1:0] bit_idx;

    adc_seq_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .start_wr (start_wr),
        .free_run (free_run),
        .adc_ce   (adc_ce),
        .busy     (busy),
        .ev       (ev),
        .bit_idx  (bit_idx)
    );

    adc_seq_selhold #(.CH_W(CH_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ev.capture),
        .finish   (ev.finish),
        .chan_sel (chan_sel),
        .ref_sel  (ref_sel),
        .mux_sel  (mux_sel),
        .ref_act  (ref_act),
        .suspect  (suspect)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (ev.sample),
        .decide_en (ev.decide),
        .finish_en (ev.finish),
        .bit_idx   (bit_idx),
        .level     (ain_level),
        .result    (result)
    );

    // Completion flag: set on finish, cleared by a write of one
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (ev.finish) done <= 1'b1;
        else if (clr_done)  done <= 1'b0;
    end

endmodule

// File: rtl/adc_conv_sequencer_chk.sv
// Module: property checker for the sequencer, bound to the top module.
// Assumes synchronous active-low reset; all properties idle during reset.
module adc_conv_sequencer_chk #(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             start_wr,
    input logic             adc_ce,
    input logic             busy,
    input logic [CH_W-1:0]  mux_sel,
    input logic [1:0]       ref_act,
    input logic [RES_W-1:0] result,
    input logic             done
);
    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && en && !busy) |=> busy);

    p_mux_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && adc_ce && en) |=> $stable(mux_sel));

    p_result_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && adc_ce && en) |=> $stable(result));

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    p_ref_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_act != 2'd3);
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .start_wr (start_wr),
    .adc_ce   (adc_ce),
    .busy     (busy),
    .mux_sel  (mux_sel),
    .ref_act  (ref_act),
    .result   (result),
    .done     (done)
);

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 10;
    localparam int CH_W  = 3;
    localparam int FULL  = (1 << RES_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, start_wr = 1'b0, free_run = 1'b0, clr_done = 1'b0;
    logic [CH_W-1:0] chan_sel = '0;
    logic [1:0] ref_sel = '0;
    logic adc_ce = 1'b0;
    logic [RES_W:0] ain_level;
    logic busy, done, suspect;
    logic [CH_W-1:0] mux_sel;
    logic [1:0] ref_act;
    logic [RES_W-1:0] result;

    int n_run = 0, n_fail = 0;
    int ce_div = 1, ce_cnt = 0;
    bit live = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lvl(int ch, int r);
        return ch * 150 + r * 37 + 5;
    endfunction

    assign ain_level = (RES_W+1)'(lvl(int'(mux_sel), int'(ref_act)));

    adc_conv_sequencer #(.RES_W(RES_W), .CH_W(CH_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_wr(start_wr),
        .free_run(free_run), .clr_done(clr_done), .chan_sel(chan_sel),
        .ref_sel(ref_sel), .adc_ce(adc_ce), .ain_level(ain_level),
        .busy(busy), .mux_sel(mux_sel), .ref_act(ref_act),
        .result(result), .done(done), .suspect(suspect)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Tick enable pattern: one in every ce_div clocks
    always @(negedge clk) begin
        adc_ce = (ce_cnt == 0);
        ce_cnt = (ce_cnt + 1 >= ce_div) ? 0 : ce_cnt + 1;
    end

    // Behavioural reference model
    int m_busy, m_cnt, m_first, m_mux, m_ref, m_pend, m_sus, m_res, m_done, m_samp;
    task automatic m_capture();
        int nr;
        nr = (ref_sel >= 2) ? 2 : int'(ref_sel);
        m_pend = (nr != m_ref);
        m_ref = nr;
        m_mux = int'(chan_sel);
    endtask

    always @(posedge clk) begin
        int fin;
        fin = 0;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_first = 0; m_mux = 0; m_ref = 0;
            m_pend = 0; m_sus = 0; m_res = 0; m_done = 0; m_samp = 0;
        end else begin
            if (!en) begin
                m_busy = 0; m_cnt = 0; m_first = 0;
            end else if (start_wr && m_busy == 0) begin
                m_busy = 1; m_cnt = 0; m_first = 1;
            end else if (m_busy == 1 && adc_ce) begin
                if (m_cnt == 0 && m_first == 1) begin m_capture(); m_first = 0; end
                if (m_cnt == 1) m_samp = lvl(m_mux, m_ref);
                if (m_cnt == RES_W + 2) begin
                    m_res = (m_samp > FULL) ? FULL : m_samp;
                    m_sus = m_pend;
                    fin = 1;
                    if (free_run) m_capture(); else m_busy = 0;
                    m_cnt = 0;
                end else m_cnt++;
            end
            if (fin == 1) m_done = 1; else if (clr_done) m_done = 0;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            check("R2 busy", int'(busy), m_busy);
            check("R3 mux_sel", int'(mux_sel), m_mux);
            check("R10 ref_act", int'(ref_act), m_ref);
            check("R5 result", int'(result), m_res);
            check("R6 done", int'(done), m_done);
            check("R7 suspect", int'(suspect), m_sus);
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) return;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        int prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        check("R1 mux/ref/suspect", int'(mux_sel) + int'(ref_act) + int'(suspect), 0);
        rst_n = 1'b1; live = 1;

        // R2 start while disabled is ignored
        pulse_start();
        @(negedge clk);
        check("R2 start ignored while disabled", int'(busy), 0);
        en = 1'b1;

        // R4 length with tick every clock: start accepted, done 14 clocks later
        ce_div = 1; chan_sel = 3'd2; ref_sel = 2'd0;
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        n = 1;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check("R4 clocks to done", n, 14);
        check("R5 result ch2", int'(result), lvl(2, 0));
        check("R2 busy cleared single", int'(busy), 0);

        // R6 clear
        pulse_clr();
        check("R6 done cleared", int'(done), 0);

        // R3 channel rewrite after capture is ignored (slow ticks)
        ce_div = 3; chan_sel = 3'd5;
        pulse_start();
        for (int i = 0; i < 20 && mux_sel != 3'd5; i++) @(negedge clk);
        chan_sel = 3'd1; ref_sel = 2'd1;
        wait_done();
        check("R3 mux held", int'(mux_sel), 5);
        check("R3 result from captured ch", int'(result), lvl(5, 0));
        check("R7 no suspect same ref", int'(suspect), 0);
        pulse_clr();

        // R5 saturation and R7 suspect on reference change
        chan_sel = 3'd7; ref_sel = 2'd2;
        pulse_start(); wait_done();
        check("R5 saturation", int'(result), FULL);
        check("R7 suspect after ref change", int'(suspect), 1);
        pulse_clr();
        // R10 code 3 equals pin source
        ref_sel = 2'd3;
        pulse_start(); wait_done();
        check("R10 ref code 3", int'(ref_act), 2);
        check("R7 suspect clears", int'(suspect), 0);
        pulse_clr();

        // R8 free running: change after first completion shows two results later
        ce_div = 1; free_run = 1'b1; chan_sel = 3'd1; ref_sel = 2'd1;
        pulse_start(); wait_done();
        check("R8 first result", int'(result), lvl(1, 1));
        chan_sel = 3'd4;
        pulse_clr(); wait_done();
        check("R8 second result old ch", int'(result), lvl(1, 1));
        pulse_clr(); wait_done();
        check("R8 third result new ch", int'(result), lvl(4, 1));
        check("R8 still busy", int'(busy), 1);
        free_run = 1'b0;
        pulse_clr(); wait_done();
        @(negedge clk);
        check("R8 stops after mode clear", int'(busy), 0);
        pulse_clr();

        // R9 abort mid-conversion
        chan_sel = 3'd6;
        prev = int'(result);
        pulse_start();
        repeat (6) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R9 busy dropped", int'(busy), 0);
        en = 1'b1;
        repeat (20) @(negedge clk);
        check("R9 result kept", int'(result), prev);
        check("R9 done kept", int'(done), 0);

        // R6 set wins over clear in same clock
        pulse_start();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            clr_done = 1'b1;
            if (done) break;
        end
        clr_done = 1'b0;
        check("R6 set wins", int'(done), 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule